// File: doc/BRIEF.md
# DDR Write Data Capture and Word Packer

This block sits on the write path of a double-data-rate memory interface. It watches the data strobe, takes one data beat and its mask bits on every strobe transition, and joins each rising-edge beat with the falling-edge beat after it. The result is one core word twice the width of the pin bus. The mask bits of the two beats are inverted to form a per-byte write-enable vector, and a one-cycle valid pulse marks each finished word.

The strobe, the DQ bus and the mask lines are sampled by a local clock that runs faster than the strobe toggles. A strobe transition is seen as a change in the sampled level between two clock edges, so the beat on the bus in that clock cycle is the one captured. A write-burst start pulse, sent with a burst-length code, arms the block for a fixed number of word pairs. Strobe transitions while the block is not armed are dropped.

Top module: `ddr_wr_capture`

## Requirements
- R1: While reset is asserted and after it is released, before any word is finished, `wr_valid` is 0, `wr_data` is 0 and `wr_be` is 0.
- R2: The beat sampled on a rising strobe transition fills `wr_data[DQ_W-1:0]`. The beat sampled on the falling transition after it fills `wr_data[2*DQ_W-1:DQ_W]`. `wr_valid` is 1 in the clock cycle right after the edge at which the falling level is first sampled.
- R3: `wr_be[i]` is the inverse of mask bit `dm[i]` of the rising beat and `wr_be[LANES+i]` is the inverse of `dm[i]` of the falling beat. Mask lane i covers DQ bits 8i+7..8i, so mask 1 means that byte is not written.
- R4: `burst_len` code 0 gives a burst of 2 beats (1 word), code 1 gives 4 beats (2 words), and codes 2 and 3 give 8 beats (4 words).
- R5: Once a burst has produced its last word, further strobe transitions produce no word until the next `wr_start`.
- R6: A `wr_start` during a burst restarts the word count with the new length and discards a rising beat that is waiting for its falling partner.
- R7: A falling transition with no rising beat waiting since the last start or the last finished word is ignored.
- R8: `wr_valid` lasts exactly one cycle per word, and `wr_data` and `wr_be` keep their last value while `wr_valid` is 0.
- R9: A strobe transition sampled in the same cycle as `wr_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | One-cycle pulse that arms a write burst |
| burst_len | input | 2 | Burst-length code sampled with `wr_start` |
| dqs | input | 1 | Write data strobe level |
| dq | input | DQ_W | Write data beat |
| dm | input | DQ_W/8 | Per-byte mask of the beat, 1 = do not write |
| wr_data | output | 2*DQ_W | Assembled core word |
| wr_be | output | DQ_W/4 | Per-byte write enables of the word |
| wr_valid | output | 1 | One-cycle pulse when a word is finished |

## Verification
Directed pairs with masks that differ between lanes and between the two beats show whether the halves or the lanes are swapped, and whether the mask is inverted. Each length code is driven with extra strobe pairs after the burst ends, so a wrong word count shows up as missing or extra words. Three sequences test the ignore rules: a restart that leaves a rising beat waiting, a start that coincides with a strobe transition, and a falling transition with no partner. Seeded random bursts with random data, masks, lengths and idle stretches then cover the combinations the directed cases miss.

// File: rtl/ddrwc_pkg.sv
`timescale 1ns/1ps
package ddrwc_pkg;

    // Burst length codes as they appear on the burst_len port
    typedef enum logic [1:0] {
        BL_TWO       = 2'd0,
        BL_FOUR      = 2'd1,
        BL_EIGHT     = 2'd2,
        BL_EIGHT_ALT = 2'd3
    } burst_code_e;

    localparam int unsigned MAX_PAIRS  = 4;
    localparam int unsigned PAIR_CNT_W = $clog2(MAX_PAIRS + 1);

    typedef logic [PAIR_CNT_W-1:0] pair_cnt_t;

    // Strobe transitions seen in one sampling cycle
    typedef struct packed {
        logic rise;
        logic fall;
    } strobe_evt_t;

    // Capture commands from the sequencer to the packer
    typedef struct packed {
        logic take_lo;
        logic take_hi;
    } capture_cmd_t;

    // Number of word pairs in a burst of the given code
    function automatic pair_cnt_t pairs_for(input burst_code_e code);
        case (code)
            BL_TWO:  return pair_cnt_t'(1);
            BL_FOUR: return pair_cnt_t'(2);
            default: return pair_cnt_t'(MAX_PAIRS);
        endcase
    endfunction

endpackage

// File: rtl/ddrwc_strobe_edge.sv
`timescale 1ns/1ps
module ddrwc_strobe_edge
    import ddrwc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    output strobe_evt_t evt
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    always_comb begin
        evt.rise = strobe & ~strobe_q;
        evt.fall = ~strobe & strobe_q;
    end

endmodule

// File: rtl/ddrwc_burst_seq.sv
`timescale 1ns/1ps
module ddrwc_burst_seq
    import ddrwc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   burst_len,
    input  strobe_evt_t  evt,
    output capture_cmd_t cmd,
    output logic         active
);

    logic      pend;
    pair_cnt_t pairs_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            pend       <= 1'b0;
            pairs_left <= '0;
        end else if (start) begin
            active     <= 1'b1;
            pend       <= 1'b0;
            pairs_left <= pairs_for(burst_code_e'(burst_len));
        end else if (active) begin
            if (evt.rise) begin
                pend <= 1'b1;
            end else if (evt.fall && pend) begin
                pend       <= 1'b0;
                pairs_left <= pairs_left - 1'b1;
                if (pairs_left == pair_cnt_t'(1)) active <= 1'b0;
            end
        end
    end

    always_comb begin
        cmd.take_lo = active & ~start & evt.rise;
        cmd.take_hi = active & ~start & evt.fall & pend;
    end

    // R4: an armed burst always has between one and MAX_PAIRS words left
    a_r4_pairs_range: assert property (@(posedge clk) disable iff (rst)
        active |-> (pairs_left != '0 && pairs_left <= pair_cnt_t'(MAX_PAIRS)));

    // R7: no rising beat is left waiting once the burst is over
    a_r7_idle_no_pend: assert property (@(posedge clk) disable iff (rst)
        !active |-> !pend);

endmodule

// File: rtl/ddrwc_word_pack.sv
`timescale 1ns/1ps
module ddrwc_word_pack
    import ddrwc_pkg::*;
#(
    parameter  int DQ_W  = 16,
    localparam int LANES = DQ_W / 8,
    localparam int WORD_W = 2 * DQ_W,
    localparam int BE_W  = 2 * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  capture_cmd_t      cmd,
    input  logic [DQ_W-1:0]   dq,
    input  logic [LANES-1:0]  dm,
    output logic [WORD_W-1:0] word_data,
    output logic [BE_W-1:0]   word_be,
    output logic              word_valid
);

    logic [DQ_W-1:0]  lo_data;
    logic [LANES-1:0] lo_mask;
    logic [BE_W-1:0]  be_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_data <= '0;
            lo_mask <= '0;
        end else if (cmd.take_lo) begin
            lo_data <= dq;
            lo_mask <= dm;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_next[g]         = ~lo_mask[g];
        assign be_next[LANES + g] = ~dm[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_data  <= '0;
            word_be    <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= cmd.take_hi;
            if (cmd.take_hi) begin
                word_data <= {dq, lo_data};
                word_be   <= be_next;
            end
        end
    end

    // R8: the word registers change only together with a valid pulse
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> ($stable(word_data) && $stable(word_be)));

endmodule

// File: rtl/ddr_wr_capture.sv
`timescale 1ns/1ps
module ddr_wr_capture
    import ddrwc_pkg::*;
#(
    parameter  int DQ_W  = 16,
    localparam int LANES = DQ_W / 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_start,
    input  logic [1:0]           burst_len,
    input  logic                 dqs,
    input  logic [DQ_W-1:0]      dq,
    input  logic [LANES-1:0]     dm,
    output logic [2*DQ_W-1:0]    wr_data,
    output logic [2*LANES-1:0]   wr_be,
    output logic                 wr_valid
);

    strobe_evt_t  evt;
    capture_cmd_t cmd;
    logic         seq_active;

    ddrwc_strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (dqs),
        .evt    (evt)
    );

    ddrwc_burst_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (wr_start),
        .burst_len (burst_len),
        .evt       (evt),
        .cmd       (cmd),
        .active    (seq_active)
    );

    ddrwc_word_pack #(.DQ_W(DQ_W)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .dq         (dq),
        .dm         (dm),
        .word_data  (wr_data),
        .word_be    (wr_be),
        .word_valid (wr_valid)
    );

    // R8: two words can never finish in adjacent cycles
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R2: a finished word always follows a sampled falling transition
    a_r2_after_fall: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(evt.fall));

    // R9: a start cycle never completes a word
    a_r9_start_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> !wr_valid);

    // R5: with no burst armed no word appears
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!seq_active && !wr_start) |=> !wr_valid);

endmodule

// File: tb/ddr_wr_capture_bench.sv
`timescale 1ns/1ps
module ddr_wr_capture_bench;

    localparam int DQ_W  = 16;
    localparam int LANES = DQ_W / 8;
    localparam int WW    = 2 * DQ_W;
    localparam int BW    = 2 * LANES;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_start = 1'b0;
    logic [1:0]       burst_len = 2'd0;
    logic             dqs = 1'b0;
    logic [DQ_W-1:0]  dq = '0;
    logic [LANES-1:0] dm = '0;
    logic [WW-1:0]    wr_data;
    logic [BW-1:0]    wr_be;
    logic             wr_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [WW-1:0] exp_d [64];
    logic [BW-1:0] exp_b [64];
    int            exp_n = 0;
    logic [WW-1:0] got_d [64];
    logic [BW-1:0] got_b [64];
    int            got_n = 0;
    logic          prev_valid = 1'b0;

    always #4 clk = ~clk;

    ddr_wr_capture #(.DQ_W(DQ_W)) u_ddr_wr_capture (
        .clk(clk), .rst(rst), .wr_start(wr_start), .burst_len(burst_len),
        .dqs(dqs), .dq(dq), .dm(dm),
        .wr_data(wr_data), .wr_be(wr_be), .wr_valid(wr_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Collects every finished word; also checks the pulse width (R8)
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                if (prev_valid) check(1'b0, "R8 pulse longer than one cycle", 64'd1, 64'd0);
                if (got_n < 64) begin
                    got_d[got_n] = wr_data;
                    got_b[got_n] = wr_be;
                end
                got_n++;
            end
            prev_valid = wr_valid;
        end
    end

    function automatic int words_for(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    task automatic beat(input logic lvl, input logic [DQ_W-1:0] d, input logic [LANES-1:0] m);
        @(negedge clk);
        dqs = lvl; dq = d; dm = m;
    endtask

    task automatic pair(input logic [DQ_W-1:0] d_lo, input logic [LANES-1:0] m_lo,
                        input logic [DQ_W-1:0] d_hi, input logic [LANES-1:0] m_hi,
                        input bit expect_it);
        beat(1'b1, d_lo, m_lo);
        beat(1'b0, d_hi, m_hi);
        if (expect_it) begin
            exp_d[exp_n] = {d_hi, d_lo};
            exp_b[exp_n] = ~{m_hi, m_lo};
            exp_n++;
        end
    endtask

    task automatic rand_pair(input bit expect_it);
        pair(DQ_W'($urandom), LANES'($urandom), DQ_W'($urandom), LANES'($urandom), expect_it);
    endtask

    task automatic start_burst(input logic [1:0] code);
        @(negedge clk);
        wr_start = 1'b1; burst_len = code;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic compare(input string req);
        logic [WW-1:0] last;
        repeat (4) @(negedge clk);
        check(got_n == exp_n, {req, " word count"}, 64'(got_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_d[i] == exp_d[i], {req, " data (R2)"}, 64'(got_d[i]), 64'(exp_d[i]));
            check(got_b[i] == exp_b[i], {req, " byte enables (R3)"}, 64'(got_b[i]), 64'(exp_b[i]));
        end
        if (exp_n > 0) begin
            last = exp_d[exp_n-1];
            check(wr_data == last, "R8 data held after pulse", 64'(wr_data), 64'(last));
        end
        got_n = 0;
        exp_n = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(wr_valid == 1'b0, "R1 valid in reset", 64'(wr_valid), 64'd0);
        check(wr_data == '0, "R1 data in reset", 64'(wr_data), 64'd0);
        check(wr_be == '0, "R1 be in reset", 64'(wr_be), 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(wr_valid == 1'b0 && wr_data == '0 && wr_be == '0,
              "R1 outputs after reset", 64'({wr_valid, wr_data}), 64'd0);

        // R2: exact cycle of the pulse and half placement
        start_burst(2'd0);
        beat(1'b1, 16'h1111, 2'b00);
        beat(1'b0, 16'h2222, 2'b00);
        @(negedge clk);
        check(wr_valid == 1'b1, "R2 valid one cycle after fall", 64'(wr_valid), 64'd1);
        check(wr_data == 32'h2222_1111, "R2 rising beat low, falling beat high",
              64'(wr_data), 64'h2222_1111);
        @(negedge clk);
        check(wr_valid == 1'b0, "R8 valid drops", 64'(wr_valid), 64'd0);
        got_n = 0;

        // R3: lane masks differ per lane and per beat
        start_burst(2'd0);
        pair(16'hA5A5, 2'b01, 16'h5A5A, 2'b10, 1'b1);
        compare("R3 mixed masks");
        start_burst(2'd0);
        pair(16'hFFFF, 2'b11, 16'h0001, 2'b00, 1'b1);
        compare("R3 low beat fully masked");

        // R4 and R5: every length code, followed by pairs outside the burst
        for (int c = 0; c < 4; c++) begin
            start_burst(2'(c));
            for (int k = 0; k < words_for(2'(c)); k++) rand_pair(1'b1);
            rand_pair(1'b0);
            rand_pair(1'b0);
            compare("R4 length code / R5 extra edges");
        end

        // R5: edges with no burst ever armed since the last one ended
        rand_pair(1'b0);
        compare("R5 idle edges");

        // R6: restart with a rising beat left waiting
        start_burst(2'd1);
        rand_pair(1'b1);
        beat(1'b1, 16'hDEAD, 2'b00);
        start_burst(2'd0);
        beat(1'b0, 16'hBEEF, 2'b00);
        rand_pair(1'b1);
        rand_pair(1'b0);
        compare("R6 restart drops waiting beat");

        // R9 and R7: rise in the start cycle, then a falling edge with no partner
        @(negedge clk);
        wr_start = 1'b1; burst_len = 2'd0; dqs = 1'b1; dq = 16'h0BAD; dm = 2'b00;
        @(negedge clk);
        wr_start = 1'b0; dqs = 1'b0; dq = 16'h0BAD;
        rand_pair(1'b1);
        compare("R9 start-cycle edge / R7 lone fall");

        // Random bursts with idle stretches and stray edges
        for (int n = 0; n < 30; n++) begin
            logic [1:0] code;
            code = 2'($urandom);
            start_burst(code);
            for (int k = 0; k < words_for(code); k++) begin
                rand_pair(1'b1);
                repeat ($urandom % 3) @(negedge clk);
            end
            if ($urandom % 2 == 1) rand_pair(1'b0);
            compare("R4 random burst");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule